// File: doc/BRIEF.md
# Conditional-Sum Adder

This block is a purely combinational binary adder of parameterised width. It takes two unsigned N-bit operands and a carry input, and it returns the N-bit sum and the carry that leaves the top bit. It does not wait for the carry to ripple across the word. Every segment of the word computes two results at once: one that assumes no carry enters the segment and one that assumes a carry does enter it. When the real carry from the segment below is known, it picks one of the two results through a 2:1 multiplexer.

The word is halved over and over until the pieces are two-bit leaf segments, and each leaf uses a short ripple chain. At every level of the tree, the lower half's pair of results is produced once and feeds both of the parent's candidate results. The carry input of the whole word acts only on the final selection. The longest path is therefore one leaf ripple plus about log2(N) multiplexer stages. N is meant to be a power of two, no smaller than the leaf width.

Top module: `cond_sum_adder`

## Requirements
- R1: `{cout, sum}` equals the (N+1)-bit value of `a + b + cin` for every combination of inputs.
- R2: Bit 0 of `sum` is the exclusive-or of `a[0]`, `b[0]` and `cin`.
- R3: `cout` is 1 exactly when `a + b + cin` is 2^N or more. It is 0 otherwise.
- R4: For the same operands, the result with `cin` = 1 is one greater, modulo 2^(N+1), than the result with `cin` = 0.
- R5: With `cin` = 0 the output equals `a + b`. The carry input only chooses between two results that are already computed, and when it is 0 it adds nothing.
- R6: All-ones plus all-ones with `cin` = 1 gives an all-ones `sum` and `cout` = 1.
- R7: All-zero operands with `cin` = 1 give `sum` = 1 and `cout` = 0. With `cin` = 0 they give zero on both outputs.
- R8: Alternating operands (`a` = 0101..., `b` = 1010...) propagate at every bit. With `cin` = 1 the result is `sum` = 0 and `cout` = 1. With `cin` = 0 the result is all ones and `cout` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand, unsigned |
| b | input | N | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of a + b + cin |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
The bench goes after the full-propagate patterns, where a carry that enters at bit 0 has to cross every segment boundary. If a multiplexer at any level were driven by the wrong half's carry or by the wrong candidate, `sum` would come out as a broken run of ones and zeros instead of clearing to zero. The all-ones case with `cin` = 1 checks the generate path together with the final carry. If the carry input were ignored, or the two candidates were swapped, the cin-pair check would fail, because the two results would no longer differ by exactly one. Random operands under a fixed seed cover the mixed generate and kill patterns at the segment seams.

// File: rtl/csa_pkg.sv
package csa_pkg;
  // one-bit sum of a full adder
  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  // one-bit carry of a full adder: majority of the three inputs
  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction
endpackage

// File: rtl/csa_leaf.sv
module csa_leaf #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s0,
  output logic [W-1:0] s1,
  output logic         c0,
  output logic         c1
);
  import csa_pkg::*;

  // two short ripple chains: carry-in assumed 0 and assumed 1
  logic [W:0] rc0;
  logic [W:0] rc1;

  always_comb begin
    rc0[0] = 1'b0;
    rc1[0] = 1'b1;
    for (int i = 0; i < W; i++) begin
      s0[i]    = fa_sum(a[i], b[i], rc0[i]);
      rc0[i+1] = fa_carry(a[i], b[i], rc0[i]);
      s1[i]    = fa_sum(a[i], b[i], rc1[i]);
      rc1[i+1] = fa_carry(a[i], b[i], rc1[i]);
    end
    c0 = rc0[W];
    c1 = rc1[W];
  end
endmodule

// File: rtl/csa_sel.sv
module csa_sel #(
  parameter int W = 2
) (
  input  logic         sel,
  input  logic [W-1:0] d0,
  input  logic [W-1:0] d1,
  output logic [W-1:0] y
);
  assign y = sel ? d1 : d0;
endmodule

// File: rtl/csa_node.sv
module csa_node #(
  parameter int W      = 32,
  parameter int LEAF_W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s0,
  output logic [W-1:0] s1,
  output logic         c0,
  output logic         c1
);
  generate
    if (W <= LEAF_W) begin : g_leaf
      csa_leaf #(.W(W)) u_leaf (
        .a(a), .b(b), .s0(s0), .s1(s1), .c0(c0), .c1(c1)
      );
    end else begin : g_split
      localparam int LO_W = W / 2;
      localparam int HI_W = W - LO_W;

      logic [LO_W-1:0] lo_s0, lo_s1;
      logic            lo_c0, lo_c1;
      logic [HI_W-1:0] hi_s0, hi_s1;
      logic            hi_c0, hi_c1;
      logic [HI_W:0]   pick0, pick1;

      csa_node #(.W(LO_W), .LEAF_W(LEAF_W)) u_lo (
        .a(a[LO_W-1:0]), .b(b[LO_W-1:0]),
        .s0(lo_s0), .s1(lo_s1), .c0(lo_c0), .c1(lo_c1)
      );

      csa_node #(.W(HI_W), .LEAF_W(LEAF_W)) u_hi (
        .a(a[W-1:LO_W]), .b(b[W-1:LO_W]),
        .s0(hi_s0), .s1(hi_s1), .c0(hi_c0), .c1(hi_c1)
      );

      // the lower half is computed once; its two carries steer the
      // upper half's pair for the node's carry-0 and carry-1 outcomes
      csa_sel #(.W(HI_W + 1)) u_pick0 (
        .sel(lo_c0), .d0({hi_c0, hi_s0}), .d1({hi_c1, hi_s1}), .y(pick0)
      );
      csa_sel #(.W(HI_W + 1)) u_pick1 (
        .sel(lo_c1), .d0({hi_c0, hi_s0}), .d1({hi_c1, hi_s1}), .y(pick1)
      );

      assign s0 = {pick0[HI_W-1:0], lo_s0};
      assign s1 = {pick1[HI_W-1:0], lo_s1};
      assign c0 = pick0[HI_W];
      assign c1 = pick1[HI_W];
    end
  endgenerate
endmodule

// File: rtl/cond_sum_adder.sv
module cond_sum_adder #(
  parameter int N      = 32,
  parameter int LEAF_W = 2
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  // whole-word candidates, brought out for the checker
  logic [N-1:0] sum_c0, sum_c1;
  logic         cout_c0, cout_c1;

  csa_node #(.W(N), .LEAF_W(LEAF_W)) u_root (
    .a(a), .b(b), .s0(sum_c0), .s1(sum_c1), .c0(cout_c0), .c1(cout_c1)
  );

  csa_sel #(.W(N + 1)) u_final (
    .sel(cin), .d0({cout_c0, sum_c0}), .d1({cout_c1, sum_c1}), .y({cout, sum})
  );
endmodule

// File: rtl/csa_checker.sv
module csa_checker #(
  parameter int N = 32
) (
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic         cin,
  input logic [N-1:0] sum,
  input logic         cout,
  input logic [N-1:0] sum_c0,
  input logic [N-1:0] sum_c1,
  input logic         cout_c0,
  input logic         cout_c1
);
  always_comb begin
    assert_total_R1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin}))
      else $error("R1 total mismatch");
    assert_lsb_R2: assert (sum[0] == (a[0] ^ b[0] ^ cin))
      else $error("R2 lsb mismatch");
    assert_cand_step_R4: assert ({cout_c1, sum_c1} == ({cout_c0, sum_c0} + 1'b1))
      else $error("R4 candidate pair mismatch");
    assert_cin0_R5: assert (cin || ({cout, sum} == {cout_c0, sum_c0}))
      else $error("R5 carry-0 candidate not chosen");
    assert_carry_mono_R3: assert (!cout_c0 || cout_c1)
      else $error("R3 carry candidates inconsistent");
  end
endmodule

bind cond_sum_adder csa_checker #(.N(N)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
  .sum_c0(sum_c0), .sum_c1(sum_c1), .cout_c0(cout_c0), .cout_c1(cout_c1)
);

// File: tb/sim_cond_sum_adder.sv
`timescale 1ns/1ps
module sim_cond_sum_adder;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic [N-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [N-1:0] sum;
  logic         cout;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cond_sum_adder #(.N(N)) u0 (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  // bench reference: bit-serial restatement of the adder
  function automatic logic [N:0] ref_add(input logic [N-1:0] x, input logic [N-1:0] y, input logic c);
    logic [N:0] r;
    logic k;
    k = c;
    for (int i = 0; i < N; i++) begin
      r[i] = x[i] ^ y[i] ^ k;
      k = (x[i] & y[i]) | (k & (x[i] | y[i]));
    end
    r[N] = k;
    return r;
  endfunction

  task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y, input logic c);
    @(negedge clk);
    a = x; b = y; cin = c;
    #1;
  endtask

  task automatic check(input string tag, input logic [N:0] got, input logic [N:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic run_vec(input logic [N-1:0] x, input logic [N-1:0] y, input logic c);
    logic [N:0] e;
    apply(x, y, c);
    e = ref_add(x, y, c);
    check("R1", {cout, sum}, e);
    check("R2", {{N{1'b0}}, sum[0]}, {{N{1'b0}}, x[0] ^ y[0] ^ c});
    check("R3", {{N{1'b0}}, cout}, {{N{1'b0}}, e[N]});
  endtask

  task automatic run_pair(input logic [N-1:0] x, input logic [N-1:0] y);
    logic [N:0] r0;
    apply(x, y, 1'b0);
    r0 = {cout, sum};
    check("R5", r0, {1'b0, x} + {1'b0, y});
    apply(x, y, 1'b1);
    check("R4", {cout, sum}, r0 + 1'b1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [N-1:0] alt;
    void'($urandom(32'h1234_5678));
    alt = '0;
    for (int i = 0; i < N; i += 2) alt[i] = 1'b1;

    // R7: zeros
    apply('0, '0, 1'b0);
    check("R7 zero", {cout, sum}, '0);
    apply('0, '0, 1'b1);
    check("R7 zero+cin", {cout, sum}, {1'b0, {(N-1){1'b0}}, 1'b1});
    // R6: all ones
    apply('1, '1, 1'b1);
    check("R6 ones", {cout, sum}, {1'b1, {N{1'b1}}});
    // R8: alternating full propagate
    apply(alt, ~alt, 1'b1);
    check("R8 alt cin1", {cout, sum}, {1'b1, {N{1'b0}}});
    apply(alt, ~alt, 1'b0);
    check("R8 alt cin0", {cout, sum}, {1'b0, {N{1'b1}}});
    apply(~alt, alt, 1'b1);
    check("R8 alt swap", {cout, sum}, {1'b1, {N{1'b0}}});
    // R3: boundary just below and at 2^N
    run_vec('1, '0, 1'b0);
    run_vec('1, '0, 1'b1);
    run_vec(alt, alt, 1'b1);
    run_pair('1, '1);
    run_pair(alt, ~alt);
    run_pair('0, '0);

    for (int n = 0; n < 400; n++) begin
      logic [N-1:0] x, y;
      x = $urandom; y = $urandom;
      if (n % 8 == 0) y = ~x;
      run_vec(x, y, n[0]);
      if (n % 4 == 0) run_pair(x, y);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule